// File: doc/BRIEF.md
# Reset-Vector Boot Sequencer with Double-Fault Halt

This block brings a processor out of reset. While the synchronous active-low reset is held, it drops any bus activity and presets the architectural state to fixed values: the status word (supervisor set, trace and master clear, interrupt mask at its top level), a zero vector base, cleared enables for the tightly coupled memories, and zeroed stack pointer and program counter. On the first clock edge after reset is released it latches two hardware configuration words into the D0 and D1 data registers. It then asks for the bus, reads two 32-bit vectors over a valid/ready read port, and hands the fetched program counter to the instruction fetch logic.

After boot it tracks whether the core is running or handling an exception. A fault reported while an exception is already being handled is fatal. The same holds for a fault on either vector read, or on the fetch of the first instruction. In each case the sequencer enters a halted state that only reset can clear. Reset always wins over every other input, and work it interrupts is never resumed.

Top module: `boot_seq`

## Requirements
- R1: At any clock edge where rst_n is low, whatever the state: the sequencer goes to RESET_HOLD; bus_req, rd_valid, ifetch_req, halted and run_start read 0 after that edge; sp_out, pc_out and vbr_out read 0.
- R2: After reset, sr_out reads 0x2700: S at bit 13 is 1, T at bit 15 is 0, M at bit 12 is 0, the mask in bits 10:8 is 7, and all other bits are 0. The value is kept until the next reset.
- R3: Reset clears mem_en. A write through mem_wr_en/mem_wr_data takes effect at the next edge only while the state is RUN. A write in any other state leaves mem_en unchanged.
- R4: d0_out/d1_out read 0 during reset. They capture cfg_word0/cfg_word1 on the first edge with rst_n high, and later changes of those inputs are ignored.
- R5: bus_req is high in BUS_REQ, READ_SP and READ_PC. No read is issued before bus_grant. Exactly two reads follow, address 0x0 then address 0x4, and each holds rd_valid and rd_addr stable until rd_ready.
- R6: The read at 0x0 loads sp_out and the read at 0x4 loads pc_out. In FETCH_FIRST, ifetch_req is high and ifetch_addr equals pc_out.
- R7: A read accepted with rd_err high moves the state to HALTED at that edge, and no further read is issued.
- R8: In FETCH_FIRST, cpu_fault moves the state to HALTED and takes priority over ifetch_done. ifetch_done alone moves it to RUN.
- R9: In RUN, exc_req or cpu_fault moves the state to EXC_PROC. In EXC_PROC, cpu_fault moves it to HALTED with priority over exc_done, and exc_done alone returns it to RUN.
- R10: In HALTED, halted is 1 and the state stays HALTED whatever the other inputs do, until rst_n is low.
- R11: run_start is high for exactly the first cycle of every stay in RUN.
- R12: state_dbg encodes RESET_HOLD=0, BUS_REQ=1, READ_SP=2, READ_PC=3, FETCH_FIRST=4, RUN=5, EXC_PROC=6, HALTED=7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_grant | input | 1 | Bus granted to the sequencer |
| bus_req | output | 1 | Bus request during the vector phase |
| rd_valid | output | 1 | Vector read request |
| rd_addr | output | ADDR_W | Vector read address |
| rd_ready | input | 1 | Read completes this cycle |
| rd_data | input | DATA_W | Read data, sampled with rd_ready |
| rd_err | input | 1 | Error flag for the completing read |
| ifetch_req | output | 1 | Request for the first instruction fetch |
| ifetch_addr | output | ADDR_W | Address of the first instruction |
| ifetch_done | input | 1 | First instruction has executed |
| cpu_fault | input | 1 | Access or address error from the core |
| exc_req | input | 1 | Core begins exception processing |
| exc_done | input | 1 | Core finishes exception processing |
| mem_wr_en | input | 1 | Write strobe for the memory enables |
| mem_wr_data | input | NUM_MEM | New memory enable bits |
| mem_en | output | NUM_MEM | Enables of the directly attached memories |
| cfg_word0 | input | DATA_W | Configuration word for D0 |
| cfg_word1 | input | DATA_W | Configuration word for D1 |
| d0_out | output | DATA_W | Data register D0 |
| d1_out | output | DATA_W | Data register D1 |
| sp_out | output | DATA_W | Loaded stack pointer |
| pc_out | output | DATA_W | Loaded program counter |
| vbr_out | output | ADDR_W | Vector base register |
| sr_out | output | 16 | Status register |
| halted | output | 1 | Double-fault halt indicator |
| run_start | output | 1 | One-cycle pulse on entry to RUN |
| state_dbg | output | 3 | Current state code |

## Verification
The bench withholds the grant and stalls rd_ready. A sequencer that read before the grant or let the address drift would show up as an unexpected or misaddressed read in the read scoreboard. It injects an error on each vector in turn and a fault during the first fetch; a design that ignored these would keep booting instead of halting. It raises a fault together with exc_done in EXC_PROC and then pulses every input in HALTED, which catches a wrong priority or a halt that leaks. It also asserts reset in the middle of the PC read, writes the memory enables outside RUN and changes the configuration inputs after capture. Each of these exposes a stale vector, a leaked enable write or a re-latched D0/D1.

// File: rtl/boot_seq_pkg.sv
// Shared definitions for the boot sequencer: state codes and status-word layout.
// Assumes a 16-bit status word whose field positions are fixed here.
package boot_seq_pkg;

    typedef enum logic [2:0] {
        ST_RESET_HOLD  = 3'd0,
        ST_BUS_REQ     = 3'd1,
        ST_READ_SP     = 3'd2,
        ST_READ_PC     = 3'd3,
        ST_FETCH_FIRST = 3'd4,
        ST_RUN         = 3'd5,
        ST_EXC_PROC    = 3'd6,
        ST_HALTED      = 3'd7
    } seq_state_e;

    localparam int SR_W       = 16;
    localparam int SR_T_BIT   = 15;
    localparam int SR_S_BIT   = 13;
    localparam int SR_M_BIT   = 12;
    localparam int SR_IPL_LSB = 8;
    localparam int IPL_W      = 3;

    // Builds the status word forced by reset.
    function automatic logic [SR_W-1:0] sr_reset_value();
        logic [SR_W-1:0] v;
        v = '0;
        v[SR_S_BIT] = 1'b1;
        v[SR_T_BIT] = 1'b0;
        v[SR_M_BIT] = 1'b0;
        v[SR_IPL_LSB +: IPL_W] = {IPL_W{1'b1}};
        return v;
    endfunction

endpackage

// File: rtl/boot_seq_fsm.sv
// Boot and fault state machine. Walks the vector fetch, the first fetch,
// run and exception phases, and latches the halted state on a double fault.
// Assumes beat_ok/beat_err are one-cycle flags for an accepted read.
module boot_seq_fsm
    import boot_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_grant,
    input  logic       beat_ok,
    input  logic       beat_err,
    input  logic       cpu_fault,
    input  logic       ifetch_done,
    input  logic       exc_req,
    input  logic       exc_done,
    output seq_state_e state,
    output logic       run_start
);

    seq_state_e state_nx;

    // Next-state choice; faults outrank completions in every state.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RESET_HOLD:  state_nx = ST_BUS_REQ;
            ST_BUS_REQ:     if (bus_grant) state_nx = ST_READ_SP;
            ST_READ_SP: begin
                if (beat_err)     state_nx = ST_HALTED;
                else if (beat_ok) state_nx = ST_READ_PC;
            end
            ST_READ_PC: begin
                if (beat_err)     state_nx = ST_HALTED;
                else if (beat_ok) state_nx = ST_FETCH_FIRST;
            end
            ST_FETCH_FIRST: begin
                if (cpu_fault)        state_nx = ST_HALTED;
                else if (ifetch_done) state_nx = ST_RUN;
            end
            ST_RUN:         if (exc_req || cpu_fault) state_nx = ST_EXC_PROC;
            ST_EXC_PROC: begin
                if (cpu_fault)     state_nx = ST_HALTED;
                else if (exc_done) state_nx = ST_RUN;
            end
            ST_HALTED:      state_nx = ST_HALTED;
        endcase
    end

    // State register and run-entry pulse; reset overrides everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_RESET_HOLD;
            run_start <= 1'b0;
        end else begin
            state     <= state_nx;
            run_start <= (state_nx == ST_RUN) && (state != ST_RUN);
        end
    end

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_HALTED |=> state == ST_HALTED); // R10
    AST_RD_ERR_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        beat_err |=> state == ST_HALTED); // R7
    AST_FETCH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_FIRST && cpu_fault) |=> state == ST_HALTED); // R8
    AST_FAULT_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXC_PROC && cpu_fault) |=> state == ST_HALTED); // R9
    AST_RUN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |=> !run_start); // R11
    AST_RUN_PULSE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |-> state == ST_RUN); // R11

endmodule

// File: rtl/boot_seq_vec_read.sv
// Vector read engine. Issues the stack-pointer and program-counter reads in
// READ_SP/READ_PC, reports accepted beats and holds the two loaded vectors.
// Assumes rd_data/rd_err are valid in the cycle rd_ready is high.
module boot_seq_vec_read
    import boot_seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int VEC_BASE   = 0,
    parameter int VEC_STRIDE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_e        state,
    input  logic              rd_ready,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_err,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              beat_ok,
    output logic              beat_err,
    output logic [DATA_W-1:0] sp_q,
    output logic [DATA_W-1:0] pc_q
);

    localparam int NUM_VEC = 2;
    localparam logic [ADDR_W-1:0] SP_ADDR = ADDR_W'(VEC_BASE);
    localparam logic [ADDR_W-1:0] PC_ADDR = ADDR_W'(VEC_BASE + VEC_STRIDE);

    logic [NUM_VEC-1:0]             slot_sel;
    logic [NUM_VEC-1:0][DATA_W-1:0] vec_q;

    // Decode which vector slot the current state is reading.
    always_comb begin
        slot_sel[0] = (state == ST_READ_SP);
        slot_sel[1] = (state == ST_READ_PC);
    end

    // Request, address and beat classification.
    always_comb begin
        rd_valid = |slot_sel;
        rd_addr  = slot_sel[1] ? PC_ADDR : SP_ADDR;
        beat_ok  = rd_valid && rd_ready && !rd_err;
        beat_err = rd_valid && rd_ready && rd_err;
    end

    // Vector holding registers, cleared by reset, loaded on a clean beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else begin
            for (int i = 0; i < NUM_VEC; i++) begin
                if (beat_ok && slot_sel[i]) vec_q[i] <= rd_data;
            end
        end
    end

    assign sp_q = vec_q[0];
    assign pc_q = vec_q[1];

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> rd_valid && $stable(rd_addr)); // R5
    AST_ONEHOT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_sel)); // R5

endmodule

// File: rtl/boot_seq_arch_regs.sv
// Architectural registers touched by reset: status word, vector base,
// memory enables and the D0/D1 configuration capture.
// Assumes the configuration inputs are stable around reset release.
module boot_seq_arch_regs
    import boot_seq_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int NUM_MEM = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  seq_state_e         state,
    input  logic [DATA_W-1:0]  cfg_word0,
    input  logic [DATA_W-1:0]  cfg_word1,
    input  logic               mem_wr_en,
    input  logic [NUM_MEM-1:0] mem_wr_data,
    output logic [SR_W-1:0]    sr_q,
    output logic [ADDR_W-1:0]  vbr_q,
    output logic [NUM_MEM-1:0] mem_en_q,
    output logic [DATA_W-1:0]  d0_q,
    output logic [DATA_W-1:0]  d1_q
);

    localparam logic [SR_W-1:0] SR_RST = sr_reset_value();

    logic cfg_capture;
    logic mem_wr_ok;

    assign cfg_capture = (state == ST_RESET_HOLD);
    assign mem_wr_ok   = mem_wr_en && (state == ST_RUN);

    // Status word and vector base: forced by reset, otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= SR_RST;
            vbr_q <= '0;
        end
    end

    // Memory enables: cleared by reset, writable only while running.
    always_ff @(posedge clk) begin
        if (!rst_n)         mem_en_q <= '0;
        else if (mem_wr_ok) mem_en_q <= mem_wr_data;
    end

    // Configuration capture on the first edge after reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d0_q <= '0;
            d1_q <= '0;
        end else if (cfg_capture) begin
            d0_q <= cfg_word0;
            d1_q <= cfg_word1;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RESET_HOLD) |=> $stable(d0_q) && $stable(d1_q)); // R4
    AST_MEMEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr_en && state == ST_RUN) |=> $stable(mem_en_q)); // R3

endmodule

// File: rtl/boot_seq.sv
// Top of the reset-vector boot sequencer. Wires the state machine, the vector
// read engine and the reset-affected registers, and decodes the status pins.
// Assumes one requester on the read port and a synchronous active-low reset.
module boot_seq
    import boot_seq_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int NUM_MEM = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_grant,
    output logic               bus_req,
    output logic               rd_valid,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic               rd_ready,
    input  logic [DATA_W-1:0]  rd_data,
    input  logic               rd_err,
    output logic               ifetch_req,
    output logic [ADDR_W-1:0]  ifetch_addr,
    input  logic               ifetch_done,
    input  logic               cpu_fault,
    input  logic               exc_req,
    input  logic               exc_done,
    input  logic               mem_wr_en,
    input  logic [NUM_MEM-1:0] mem_wr_data,
    output logic [NUM_MEM-1:0] mem_en,
    input  logic [DATA_W-1:0]  cfg_word0,
    input  logic [DATA_W-1:0]  cfg_word1,
    output logic [DATA_W-1:0]  d0_out,
    output logic [DATA_W-1:0]  d1_out,
    output logic [DATA_W-1:0]  sp_out,
    output logic [DATA_W-1:0]  pc_out,
    output logic [ADDR_W-1:0]  vbr_out,
    output logic [15:0]        sr_out,
    output logic               halted,
    output logic               run_start,
    output logic [2:0]         state_dbg
);

    seq_state_e  state;
    logic        beat_ok;
    logic        beat_err;

    boot_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_grant   (bus_grant),
        .beat_ok     (beat_ok),
        .beat_err    (beat_err),
        .cpu_fault   (cpu_fault),
        .ifetch_done (ifetch_done),
        .exc_req     (exc_req),
        .exc_done    (exc_done),
        .state       (state),
        .run_start   (run_start)
    );

    boot_seq_vec_read #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_vec (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .rd_ready (rd_ready),
        .rd_data  (rd_data),
        .rd_err   (rd_err),
        .rd_valid (rd_valid),
        .rd_addr  (rd_addr),
        .beat_ok  (beat_ok),
        .beat_err (beat_err),
        .sp_q     (sp_out),
        .pc_q     (pc_out)
    );

    boot_seq_arch_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .NUM_MEM (NUM_MEM)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .cfg_word0   (cfg_word0),
        .cfg_word1   (cfg_word1),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_data (mem_wr_data),
        .sr_q        (sr_out),
        .vbr_q       (vbr_out),
        .mem_en_q    (mem_en),
        .d0_q        (d0_out),
        .d1_q        (d1_out)
    );

    // Status pins decoded from the current state.
    always_comb begin
        bus_req     = (state == ST_BUS_REQ) || (state == ST_READ_SP) ||
                      (state == ST_READ_PC);
        ifetch_req  = (state == ST_FETCH_FIRST);
        ifetch_addr = ADDR_W'(pc_out);
        halted      = (state == ST_HALTED);
        state_dbg   = state;
    end

    AST_NO_READ_UNGRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUS_REQ && !bus_grant) |=> !rd_valid); // R5
    AST_FETCH_AT_PC: assert property (@(posedge clk) disable iff (!rst_n)
        ifetch_req |-> ifetch_addr == ADDR_W'(pc_out) && !bus_req); // R6

endmodule

// File: tb/tb_boot_seq.sv
// Scoreboard bench: tasks push expected reads and run entries into queues,
// a negedge monitor pops and compares them; directed checks cover the rest.
module tb_boot_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_grant = 1'b0;
    logic        bus_req, rd_valid, rd_ready = 1'b1, rd_err;
    logic [31:0] rd_addr, rd_data;
    logic        ifetch_req, ifetch_done = 1'b0;
    logic [31:0] ifetch_addr;
    logic        cpu_fault = 1'b0, exc_req = 1'b0, exc_done = 1'b0;
    logic        mem_wr_en = 1'b0;
    logic [1:0]  mem_wr_data = 2'b00, mem_en;
    logic [31:0] cfg0 = 32'h0, cfg1 = 32'h0;
    logic [31:0] d0_out, d1_out, sp_out, pc_out, vbr_out;
    logic [15:0] sr_out;
    logic        halted, run_start;
    logic [2:0]  state_dbg;

    logic [31:0] mem_sp = 32'h0, mem_pc = 32'h0;
    logic        err_sp = 1'b0, err_pc = 1'b0;

    int vec_cnt = 0;
    int err_cnt = 0;
    logic [31:0] exp_addr_q[$];
    logic [63:0] exp_run_q[$];

    always #4 clk = ~clk;

    assign rd_data = (rd_addr == 32'h0) ? mem_sp :
                     (rd_addr == 32'h4) ? mem_pc : 32'hBAD0_BAD0;
    assign rd_err  = (rd_addr == 32'h0) ? err_sp :
                     (rd_addr == 32'h4) ? err_pc : 1'b1;

    boot_seq dut (
        .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant), .bus_req(bus_req),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rd_data(rd_data), .rd_err(rd_err), .ifetch_req(ifetch_req),
        .ifetch_addr(ifetch_addr), .ifetch_done(ifetch_done),
        .cpu_fault(cpu_fault), .exc_req(exc_req), .exc_done(exc_done),
        .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data), .mem_en(mem_en),
        .cfg_word0(cfg0), .cfg_word1(cfg1), .d0_out(d0_out), .d1_out(d1_out),
        .sp_out(sp_out), .pc_out(pc_out), .vbr_out(vbr_out), .sr_out(sr_out),
        .halted(halted), .run_start(run_start), .state_dbg(state_dbg)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            err_cnt++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Monitor: compares accepted reads and run entries with the queues.
    always @(negedge clk) begin
        if (rst_n && rd_valid && rd_ready) begin
            if (exp_addr_q.size() == 0) begin
                vec_cnt++;
                err_cnt++;
                $display("FAIL R5 unexpected read: actual addr %h expected none", rd_addr);
            end else begin
                chk("R5 read address", rd_addr, exp_addr_q.pop_front());
            end
        end
        if (run_start) begin
            if (exp_run_q.size() == 0) begin
                vec_cnt++;
                err_cnt++;
                $display("FAIL R11 unexpected run_start: actual 1 expected 0");
            end else begin
                chk("R6/R11 sp,pc at run entry", {sp_out, pc_out}, exp_run_q.pop_front());
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) step();
        chk("R1 state in reset", state_dbg, 3'd0);
        chk("R1 outputs in reset", {bus_req, rd_valid, ifetch_req, halted, run_start}, 5'b0);
        chk("R1 sp/pc/vbr in reset", {sp_out, pc_out, vbr_out}, 96'h0);
        chk("R2 status word", sr_out, 16'h2700);
        chk("R3 mem_en cleared", mem_en, 2'b00);
        chk("R4 d0/d1 zero in reset", {d0_out, d1_out}, 64'h0);
    endtask

    task automatic wait_state(input logic [2:0] st, input string tag);
        for (int i = 0; i < 20 && state_dbg != st; i++) step();
        chk(tag, state_dbg, st);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        err_cnt++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    end

    initial begin
        // ---- Test A: full boot with grant delay and read stall ----
        mem_sp = 32'h0001_0F00; mem_pc = 32'h0000_0400;
        cfg0 = 32'h1234_5678; cfg1 = 32'hCAFE_0001;
        rd_ready = 1'b0;
        do_reset();
        exp_addr_q.push_back(32'h0); exp_addr_q.push_back(32'h4);
        exp_run_q.push_back({32'h0001_0F00, 32'h0000_0400});
        exp_run_q.push_back({32'h0001_0F00, 32'h0000_0400});
        rst_n = 1'b1;
        step();
        chk("R12 BUS_REQ code", state_dbg, 3'd1);
        chk("R4 config captured", {d0_out, d1_out}, {32'h1234_5678, 32'hCAFE_0001});
        chk("R5 bus_req without read", {bus_req, rd_valid}, 2'b10);
        cfg0 = 32'hFFFF_0000; cfg1 = 32'h0000_FFFF;
        repeat (3) step();
        chk("R5 no read before grant", {state_dbg, rd_valid}, {3'd1, 1'b0});
        chk("R4 later config ignored", {d0_out, d1_out}, {32'h1234_5678, 32'hCAFE_0001});
        bus_grant = 1'b1;
        step();
        chk("R5 SP read issued", {state_dbg, rd_valid, rd_addr}, {3'd2, 1'b1, 32'h0});
        repeat (2) step();
        chk("R5 SP read held while stalled", {state_dbg, rd_valid, rd_addr}, {3'd2, 1'b1, 32'h0});
        rd_ready = 1'b1;
        step();
        chk("R6 sp loaded", {state_dbg, sp_out}, {3'd3, 32'h0001_0F00});
        step();
        chk("R6 pc loaded, fetch", {state_dbg, pc_out, ifetch_req, ifetch_addr, bus_req},
            {3'd4, 32'h0000_0400, 1'b1, 32'h0000_0400, 1'b0});
        ifetch_done = 1'b1;
        step();
        ifetch_done = 1'b0;
        chk("R8/R11 RUN with pulse", {state_dbg, run_start}, {3'd5, 1'b1});
        step();
        chk("R11 pulse one cycle", run_start, 1'b0);
        mem_wr_en = 1'b1; mem_wr_data = 2'b11;
        step();
        mem_wr_en = 1'b0;
        chk("R3 write in RUN", mem_en, 2'b11);
        exc_req = 1'b1;
        step();
        exc_req = 1'b0;
        chk("R9 RUN to EXC_PROC", state_dbg, 3'd6);
        mem_wr_en = 1'b1; mem_wr_data = 2'b00;
        step();
        mem_wr_en = 1'b0;
        chk("R3 write outside RUN ignored", mem_en, 2'b11);
        exc_done = 1'b1;
        step();
        exc_done = 1'b0;
        chk("R9/R11 back to RUN with pulse", {state_dbg, run_start}, {3'd5, 1'b1});
        cpu_fault = 1'b1;
        step();
        chk("R9 fault in RUN is exception", state_dbg, 3'd6);
        exc_done = 1'b1;
        step();
        chk("R9 fault on fault halts", {state_dbg, halted}, {3'd7, 1'b1});
        cpu_fault = 1'b0; exc_req = 1'b1;
        repeat (3) step();
        exc_done = 1'b0; exc_req = 1'b0;
        chk("R10 halt sticky", {state_dbg, halted, rd_valid}, {3'd7, 1'b1, 1'b0});
        chk("R2 status word kept", sr_out, 16'h2700);

        // ---- Test B: reset aborts a PC read ----
        do_reset();
        chk("R10 reset leaves halt", halted, 1'b0);
        exp_addr_q.push_back(32'h0);
        rst_n = 1'b1;
        wait_state(3'd3, "R5 reach READ_PC");
        rd_ready = 1'b0;
        step();
        chk("R6 sp before abort", sp_out, 32'h0001_0F00);
        rst_n = 1'b0;
        step();
        chk("R1 abort mid-read", {state_dbg, rd_valid, bus_req, sp_out}, {3'd0, 1'b0, 1'b0, 32'h0});
        rd_ready = 1'b1;

        // ---- Test C: error on SP read ----
        do_reset();
        err_sp = 1'b1;
        exp_addr_q.push_back(32'h0);
        rst_n = 1'b1;
        wait_state(3'd2, "R5 reach READ_SP");
        step();
        chk("R7 SP error halts", {state_dbg, halted}, {3'd7, 1'b1});
        repeat (2) step();
        chk("R7 no read after error", rd_valid, 1'b0);
        err_sp = 1'b0;

        // ---- Test D: error on PC read ----
        do_reset();
        err_pc = 1'b1;
        exp_addr_q.push_back(32'h0); exp_addr_q.push_back(32'h4);
        rst_n = 1'b1;
        wait_state(3'd3, "R5 reach READ_PC");
        step();
        chk("R7 PC error halts", {state_dbg, halted, rd_valid}, {3'd7, 1'b1, 1'b0});
        err_pc = 1'b0;

        // ---- Test E: fault during first fetch, new vectors ----
        mem_sp = 32'h2000_0000; mem_pc = 32'h0000_1234;
        cfg0 = 32'hA5A5_0000; cfg1 = 32'h0000_5A5A;
        do_reset();
        exp_addr_q.push_back(32'h0); exp_addr_q.push_back(32'h4);
        rst_n = 1'b1;
        step();
        chk("R4 new config captured", {d0_out, d1_out}, {32'hA5A5_0000, 32'h0000_5A5A});
        wait_state(3'd4, "R6 reach FETCH_FIRST");
        chk("R6 new vectors", {sp_out, pc_out, ifetch_addr}, {32'h2000_0000, 32'h0000_1234, 32'h0000_1234});
        cpu_fault = 1'b1; ifetch_done = 1'b1;
        step();
        cpu_fault = 1'b0; ifetch_done = 1'b0;
        chk("R8 fault before first insn halts", {state_dbg, halted, run_start}, {3'd7, 1'b1, 1'b0});

        step();
        chk("R5 read queue drained", exp_addr_q.size(), 0);
        chk("R11 run queue drained", exp_run_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    end

endmodule